// File: doc/BRIEF.md
# Sudoku Placement Conflict Checker

This block judges one freshly written cell of a 9x9 puzzle grid. A request names the cell by its linear index, and the whole grid arrives on a flat bus in the same cycle. The block then looks for another cell holding the same digit. It searches three groups at the same time: the row of the named cell, its column, and its 3x3 box. One registered clock later it reports which of the three groups clash, together with a combined verdict.

A search engine uses the block after each tentative placement. A clean verdict lets the engine move on to the next empty cell. A clash tells it to try the next digit or to backtrack. Cells that hold zero are empty and can never clash. The named cell is never compared with itself.

The grid side is set by the box side parameter (3 by default). Every width is derived from that parameter.

Top module: `cell_conflict_check`

## Requirements
- R1: `respValid` is high for exactly the one cycle after each rising clock edge at which `reqValid` was high, and is low in every other cycle.
- R2: Whenever `respValid` is high, `respOk` is 1 if and only if `rowHit`, `colHit` and `boxHit` are all 0.
- R3: `rowHit` is 1 when some other cell with the same row number (index divided by 9) holds the named cell's nonzero digit. Cell i occupies `gridFlat[4*i+3:4*i]`, and i = row*9 + col.
- R4: `colHit` is 1 when some other cell with the same column number (index modulo 9) holds the named cell's nonzero digit.
- R5: `boxHit` is 1 when some other cell holds the named cell's nonzero digit in the 3x3 box whose top-left corner is at the row and column each rounded down to a multiple of 3. A matching digit just outside that box in both row and column gives no hit.
- R6: If the named cell holds 0, the result has `respOk` = 1 and all three hit flags 0, whatever the rest of the grid holds.
- R7: Other cells holding 0 never produce a hit.
- R8: The named cell is excluded from its own comparisons. A digit with no duplicate in its row, column and box gives `respOk` = 1.
- R9: After reset, `respValid` = 0, `respOk` = 1 and all hit flags are 0.
- R10: Between results, `respOk` and the hit flags keep the last result. Changes on `gridFlat` or `reqIndex` while `reqValid` is low have no effect on them.
- R11: Requests on consecutive cycles each produce their own correct result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Check request for the cell named by `reqIndex` |
| reqIndex | input | 7 | Linear cell index, row*9 + col, range 0 to 80 |
| gridFlat | input | 324 | Grid contents, 4 bits per cell, cell i at bits 4*i+3..4*i |
| respValid | output | 1 | One-cycle strobe marking a fresh result |
| respOk | output | 1 | 1 when the placement clashes with nothing |
| rowHit | output | 1 | Duplicate found in the cell's row |
| colHit | output | 1 | Duplicate found in the cell's column |
| boxHit | output | 1 | Duplicate found in the cell's 3x3 box |

## Verification
The properties assume that `reqIndex` stays below 81 whenever `reqValid` is high. They also assume that every cell nibble holds a value from 0 to 9. They judge an empty target from the grid and index sampled at the request edge. The stimulus only ever forms indices as a value modulo 81 and only writes digits from 0 to 9. Outside a request it changes the grid and index freely, so the holding behaviour is exercised against that same contract.

// File: rtl/cc_pkg.sv
package cc_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // latch the three group verdicts this edge
  } ctlStrobe_t;

  // Group selector values used by the scan units.
  localparam int GROUP_ROW = 0;
  localparam int GROUP_COL = 1;
  localparam int GROUP_BOX = 2;
  localparam int GROUP_COUNT = 3;

endpackage

// File: rtl/cc_group_scan.sv
// Scans one group (row, column or box) of the target cell for a duplicate digit.
module cc_group_scan #(
  parameter  int BOX   = 3,
  parameter  int KIND  = cc_pkg::GROUP_ROW,
  localparam int SIDE  = BOX * BOX,
  localparam int CELLS = SIDE * SIDE,
  localparam int DW    = $clog2(SIDE + 1),
  localparam int RW    = $clog2(SIDE),
  localparam int IW    = $clog2(CELLS)
) (
  input  logic [CELLS*DW-1:0] gridFlat,
  input  logic [IW-1:0]       tgtIdx,
  input  logic [RW-1:0]       tgtRow,
  input  logic [RW-1:0]       tgtCol,
  input  logic [DW-1:0]       tgtVal,
  output logic                hit
);

  logic [RW-1:0]   baseRow;
  logic [RW-1:0]   baseCol;
  logic [SIDE-1:0] memHit;

  assign baseRow = RW'(tgtRow - RW'(tgtRow % BOX));
  assign baseCol = RW'(tgtCol - RW'(tgtCol % BOX));

  for (genvar k = 0; k < SIDE; k++) begin : gMember
    logic [IW-1:0] memIdx;
    logic [DW-1:0] memVal;

    if (KIND == cc_pkg::GROUP_ROW) begin : gRow
      assign memIdx = IW'(tgtRow * SIDE + k);
    end else if (KIND == cc_pkg::GROUP_COL) begin : gCol
      assign memIdx = IW'(k * SIDE + tgtCol);
    end else begin : gBox
      assign memIdx = IW'((baseRow + k / BOX) * SIDE + baseCol + k % BOX);
    end

    assign memVal    = gridFlat[memIdx*DW +: DW];
    assign memHit[k] = (memIdx != tgtIdx) && (tgtVal != '0) && (memVal == tgtVal);
  end

  assign hit = |memHit;

endmodule

// File: rtl/cc_datapath.sv
// Decodes the target position, runs the three group scans and holds the verdict.
module cc_datapath #(
  parameter  int BOX   = 3,
  localparam int SIDE  = BOX * BOX,
  localparam int CELLS = SIDE * SIDE,
  localparam int DW    = $clog2(SIDE + 1),
  localparam int RW    = $clog2(SIDE),
  localparam int IW    = $clog2(CELLS),
  localparam int NG    = cc_pkg::GROUP_COUNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cc_pkg::ctlStrobe_t ctl,
  input  logic [IW-1:0]       reqIndex,
  input  logic [CELLS*DW-1:0] gridFlat,
  output logic [NG-1:0]       hitReg,
  output logic                okReg
);

  logic [RW-1:0] tgtRow;
  logic [RW-1:0] tgtCol;
  logic [DW-1:0] tgtVal;
  logic [NG-1:0] groupHit;

  assign tgtRow = RW'(reqIndex / SIDE);
  assign tgtCol = RW'(reqIndex % SIDE);
  assign tgtVal = gridFlat[reqIndex*DW +: DW];

  for (genvar g = 0; g < NG; g++) begin : gUnit
    cc_group_scan #(.BOX(BOX), .KIND(g)) u_scan (
      .gridFlat (gridFlat),
      .tgtIdx   (reqIndex),
      .tgtRow   (tgtRow),
      .tgtCol   (tgtCol),
      .tgtVal   (tgtVal),
      .hit      (groupHit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitReg <= '0;
      okReg  <= 1'b1;
    end else if (ctl.capture) begin
      hitReg <= groupHit;
      okReg  <= ~|groupHit;
    end
  end

endmodule

// File: rtl/cc_ctrl.sv
// Turns a request into a capture strobe and a one-cycle result strobe.
module cc_ctrl (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  output cc_pkg::ctlStrobe_t ctl,
  output logic               respValid
);

  always_comb begin
    ctl.capture = reqValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) respValid <= 1'b0;
    else        respValid <= reqValid;
  end

endmodule

// File: rtl/cell_conflict_check.sv
module cell_conflict_check #(
  parameter  int BOX   = 3,
  localparam int SIDE  = BOX * BOX,
  localparam int CELLS = SIDE * SIDE,
  localparam int DW    = $clog2(SIDE + 1),
  localparam int IW    = $clog2(CELLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [IW-1:0]       reqIndex,
  input  logic [CELLS*DW-1:0] gridFlat,
  output logic               respValid,
  output logic               respOk,
  output logic               rowHit,
  output logic               colHit,
  output logic               boxHit
);

  cc_pkg::ctlStrobe_t ctl;
  logic [cc_pkg::GROUP_COUNT-1:0] hitReg;

  cc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .ctl       (ctl),
    .respValid (respValid)
  );

  cc_datapath #(.BOX(BOX)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .reqIndex (reqIndex),
    .gridFlat (gridFlat),
    .hitReg   (hitReg),
    .okReg    (respOk)
  );

  assign rowHit = hitReg[cc_pkg::GROUP_ROW];
  assign colHit = hitReg[cc_pkg::GROUP_COL];
  assign boxHit = hitReg[cc_pkg::GROUP_BOX];

endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
  parameter  int BOX   = 3,
  localparam int SIDE  = BOX * BOX,
  localparam int CELLS = SIDE * SIDE,
  localparam int DW    = $clog2(SIDE + 1),
  localparam int IW    = $clog2(CELLS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reqValid,
  input logic [IW-1:0]       reqIndex,
  input logic [CELLS*DW-1:0] gridFlat,
  input logic               respValid,
  input logic               respOk,
  input logic               rowHit,
  input logic               colHit,
  input logic               boxHit
);

  logic [DW-1:0] tgtNibble;
  assign tgtNibble = gridFlat[reqIndex*DW +: DW];

  assert_pulse_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> respValid);

  assert_pulse_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !respValid);

  assert_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> (respOk == !(rowHit || colHit || boxHit)));

  assert_empty_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && tgtNibble == '0) |=> (respOk && !rowHit && !colHit && !boxHit));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> $stable({respOk, rowHit, colHit, boxHit}));

endmodule

bind cell_conflict_check cc_checker #(.BOX(BOX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqIndex  (reqIndex),
  .gridFlat  (gridFlat),
  .respValid (respValid),
  .respOk    (respOk),
  .rowHit    (rowHit),
  .colHit    (colHit),
  .boxHit    (boxHit)
);

// File: tb/sim_cell_conflict_check.sv
`timescale 1ns/1ps
module sim_cell_conflict_check;

  localparam int CELLS = 81;
  localparam int DW    = 4;
  localparam int IW    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [IW-1:0] reqIndex = '0;
  logic [CELLS*DW-1:0] gridFlat = '0;
  logic respValid, respOk, rowHit, colHit, boxHit;

  typedef struct {
    logic ok;
    logic row;
    logic col;
    logic box;
    string tag;
  } exp_t;

  exp_t q[$];
  int nChecks = 0;
  int nFails = 0;
  logic [3:0] lastVec = 4'b1000;

  always #4 clk = ~clk;

  cell_conflict_check u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIndex(reqIndex),
    .gridFlat(gridFlat), .respValid(respValid), .respOk(respOk),
    .rowHit(rowHit), .colHit(colHit), .boxHit(boxHit)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!cond) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic void setCell(input int i, input int v);
    gridFlat[i*DW +: DW] = DW'(v);
  endfunction

  function automatic int getCell(input int i);
    return int'(gridFlat[i*DW +: DW]);
  endfunction

  function automatic exp_t model(input int idx, input string tag);
    exp_t e;
    int v, r, c;
    v = getCell(idx);
    r = idx / 9;
    c = idx % 9;
    e.row = 0; e.col = 0; e.box = 0; e.tag = tag;
    if (v != 0) begin
      for (int j = 0; j < CELLS; j++) begin
        if (j != idx && getCell(j) == v) begin
          if (j / 9 == r) e.row = 1;
          if (j % 9 == c) e.col = 1;
          if ((j / 9) / 3 == r / 3 && (j % 9) / 3 == c / 3) e.box = 1;
        end
      end
    end
    e.ok = !(e.row || e.col || e.box);
    return e;
  endfunction

  // Driver: called at a falling edge; leaves the request up for one cycle.
  task automatic request(input int idx, input string tag);
    reqIndex = IW'(idx);
    q.push_back(model(idx, tag));
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  // Scoreboard monitor (R1, R2..R8, R11 via tags).
  always @(negedge clk) begin
    if (rst_n) begin
      if (respValid) begin
        if (q.size() == 0) begin
          check(0, "R1", "unexpected respValid", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(respOk == e.ok,  e.tag, "respOk", int'(respOk), int'(e.ok));
          check(rowHit == e.row, e.tag, "rowHit", int'(rowHit), int'(e.row));
          check(colHit == e.col, e.tag, "colHit", int'(colHit), int'(e.col));
          check(boxHit == e.box, e.tag, "boxHit", int'(boxHit), int'(e.box));
          check(respOk == !(rowHit || colHit || boxHit), "R2", "verdict vs flags",
                int'(respOk), int'(!(rowHit || colHit || boxHit)));
        end
        lastVec = {respOk, rowHit, colHit, boxHit};
      end
    end
  end

  task automatic clearGrid();
    gridFlat = '0;
  endtask

  function automatic int solvedVal(input int i);
    int r, c;
    r = i / 9;
    c = i % 9;
    return ((r * 3 + r / 3 + c) % 9) + 1;
  endfunction

  initial begin : watchdog
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(respValid == 0, "R9", "respValid after reset", int'(respValid), 0);
    check(respOk == 1, "R9", "respOk after reset", int'(respOk), 1);
    check({rowHit, colHit, boxHit} == 3'b000, "R9", "hits after reset",
          int'({rowHit, colHit, boxHit}), 0);

    // R6: empty grid, empty target
    clearGrid();
    request(40, "R6");
    drain();

    // R8 / R7: lone digit among empty cells
    setCell(40, 5);
    request(40, "R8");
    drain();

    // R3: row clash (row 4, col 0)
    setCell(36, 5);
    request(40, "R3");
    drain();
    setCell(36, 0);

    // R4: column clash (row 0, col 4)
    setCell(4, 5);
    request(40, "R4");
    drain();
    setCell(4, 0);

    // R5: box clash only (row 3, col 3)
    setCell(30, 5);
    request(40, "R5");
    drain();
    setCell(30, 0);

    // R5 boundary: row 3, col 6 is outside box, row and column
    setCell(33, 5);
    request(40, "R5");
    drain();
    check(respOk == 1, "R5", "outside-box digit ok", int'(respOk), 1);

    // R6: empty target surrounded by duplicates
    clearGrid();
    setCell(1, 7); setCell(9, 7); setCell(10, 7); setCell(2, 7);
    request(0, "R6");
    drain();

    // R10: hold while idle with inputs churning
    begin
      logic [3:0] held;
      held = lastVec;
      for (int k = 0; k < 4; k++) begin
        for (int j = 0; j < CELLS; j++) setCell(j, $urandom % 10);
        reqIndex = IW'($urandom % CELLS);
        @(negedge clk);
        check(respValid == 0, "R10", "no strobe when idle", int'(respValid), 0);
        check({respOk, rowHit, colHit, boxHit} == held, "R10", "result held",
              int'({respOk, rowHit, colHit, boxHit}), int'(held));
      end
    end

    // R11 / R8: solved grid, every cell back-to-back
    for (int j = 0; j < CELLS; j++) setCell(j, solvedVal(j));
    for (int j = 0; j < CELLS; j++) request(j, "R11");
    drain();

    // Corrupt corner cells and recheck (R3/R4/R5 corners 0 and 80)
    setCell(0, solvedVal(80));
    setCell(80, solvedVal(1));
    request(0, "R3");
    request(80, "R4");
    request(72, "R5");
    drain();

    // Sparse random grids vs reference model (R3, R4, R5, R7)
    for (int t = 0; t < 400; t++) begin
      int idx;
      clearGrid();
      for (int k = 0; k < 14; k++) setCell($urandom % CELLS, ($urandom % 9) + 1);
      idx = $urandom % CELLS;
      if (t % 5 != 0) setCell(idx, ($urandom % 9) + 1);
      request(idx, "R7");
    end
    drain();

    check(q.size() == 0, "R1", "results outstanding", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule